// File: doc/BRIEF.md
# Accelerator Argument and Control Adapter

This block sits between a host on an AXI4-Lite bus and a tiny compute core that forms `c_out = c_in + a + b` on 8-bit operands (the sum wraps modulo 256). The host loads the three operands into word registers, then sets a start bit in the control word. The core then stalls until the host raises a per-argument valid flag for `b`. When that flag is seen, the core samples `a`, `b` and `c_in` in the same cycle, clears the `b` flag and posts the result together with an output-valid flag.

Completion is tied to the host taking the result. The done bit in the control word is raised only when the host reads the result word. That read also clears the output-valid flag, and the core goes back to idle. Each access is one word. The write address and write data channels may arrive in any order.

Register map (word aligned; bit 0 is the least significant):
- 0x00 control: bit 0 start (write 1 while idle), bit 1 done (cleared when this word is read), bit 2 idle (read only).
- 0x10 `a`, 0x18 `b`, 0x20 `c_in`: 8-bit data words.
- 0x1c: `b` valid flag, bit 0.
- 0x28: `c_out`, read only.
- 0x2c: `c_out` valid flag, bit 0, read only.
- 0x24 and every other offset is reserved.

Top module: `accel_ctl_adapter`

## Requirements
- R1: After reset, the control word at 0x00 reads 0x4, which is idle only. The `b` valid word 0x1c, the result word 0x28 and the result-valid word 0x2c all read 0.
- R2: The data words at 0x10, 0x18 and 0x20 keep only bits [7:0] of a write. Bits [31:8] of every read return 0.
- R3: The write response (bvalid with bresp = 0 OKAY) comes only after both the address and the data of a write have been accepted. This holds whether they arrive together, address first or data first. bvalid stays high until bready.
- R4: Writing 1 to bit 0 of 0x00 while idle starts the core. The start bit then clears by itself and idle (bit 2) reads 0 until the run ends. A start written while the core is busy is ignored and does not cause a second run.
- R5: After a start, while the `b` valid flag (0x1c bit 0) is 0, the core makes no progress. 0x2c stays 0 and idle stays 0.
- R6: Once the `b` valid flag is 1, the core consumes it. 0x1c then reads 0, 0x28 holds (c_in + a + b) mod 256, and 0x2c reads 1.
- R7: `a` is sampled at the moment `b` is consumed. A write to 0x10 made during the stall is the value used.
- R8: The done bit stays 0 while the result is posted but unread. A host read of 0x28 clears 0x2c, sets done and returns the core to idle, so 0x00 then reads 0x6.
- R9: Reading 0x00 clears the done bit. The next read returns 0x4.
- R10: Reads of 0x24 and of unmapped offsets return 0 with rresp OKAY. Writes to them change no readable state.
- R11: A read response holds rvalid and rdata unchanged until the host raises rready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_awaddr | input | ADDR_W | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write byte strobes (lane 0 gates every register) |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response, always OKAY |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | ADDR_W | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response, always OKAY |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |

## Verification
The sequencer state can be seen at the ports through the control word and the two valid flags. A core stuck in or skipping its wait state shows up on the very next read: either idle reads wrong or 0x2c rises while the `b` flag is still 0. A missed clear of the `b` flag or of done appears as a stale 1 on the following read of 0x1c or 0x00. A wrong sum or a stale sample of `a` appears only in the single read of 0x28, so each run reads that word exactly once, after changing `a` during the stall. A write-channel ordering fault is exposed by an early bvalid while only one channel has been accepted.

// File: rtl/acc_pkg.sv
package acc_pkg;
  localparam int BUS_W  = 32;
  localparam int ARG_W  = 8;
  // word indices (byte offset / 4)
  localparam int WI_CTRL = 0;
  localparam int WI_A    = 4;
  localparam int WI_B    = 6;
  localparam int WI_BV   = 7;
  localparam int WI_CI   = 8;
  localparam int WI_CO   = 10;
  localparam int WI_COV  = 11;

  typedef enum logic [1:0] {CS_IDLE, CS_WAIT, CS_POST} core_state_t;

  function automatic logic [ARG_W-1:0] acc_sum(input logic [ARG_W-1:0] c,
                                                input logic [ARG_W-1:0] a,
                                                input logic [ARG_W-1:0] b);
    logic [ARG_W+1:0] t;
    t = {2'b00, c} + {2'b00, a} + {2'b00, b};
    return t[ARG_W-1:0];
  endfunction
endpackage

// File: rtl/acc_axil_port.sv
module acc_axil_port #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     awaddr,
  input  logic                  awvalid,
  output logic                  awready,
  input  logic [DATA_W-1:0]     wdata,
  input  logic [DATA_W/8-1:0]   wstrb,
  input  logic                  wvalid,
  output logic                  wready,
  output logic                  bvalid,
  input  logic                  bready,
  input  logic [ADDR_W-1:0]     araddr,
  input  logic                  arvalid,
  output logic                  arready,
  output logic [DATA_W-1:0]     rdata,
  output logic                  rvalid,
  input  logic                  rready,
  output logic                  wr_fire,
  output logic [ADDR_W-1:0]     wr_addr,
  output logic [DATA_W-1:0]     wr_data,
  output logic [DATA_W/8-1:0]   wr_strb,
  output logic                  rd_fire,
  output logic [ADDR_W-1:0]     rd_addr,
  input  logic [DATA_W-1:0]     rd_word
);
  localparam int STRB_W = DATA_W / 8;

  logic              aw_held, w_held;
  logic [ADDR_W-1:0] aw_q;
  logic [DATA_W-1:0] w_q;
  logic [STRB_W-1:0] s_q;
  logic              aw_take, w_take;

  assign awready = !aw_held && !bvalid;
  assign wready  = !w_held && !bvalid;
  assign aw_take = awvalid && awready;
  assign w_take  = wvalid && wready;
  assign wr_fire = aw_held && w_held && !bvalid;
  assign wr_addr = aw_q;
  assign wr_data = w_q;
  assign wr_strb = s_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      aw_held <= 1'b0;
      w_held  <= 1'b0;
      aw_q    <= '0;
      w_q     <= '0;
      s_q     <= '0;
      bvalid  <= 1'b0;
    end else begin
      if (aw_take) begin
        aw_held <= 1'b1;
        aw_q    <= awaddr;
      end
      if (w_take) begin
        w_held <= 1'b1;
        w_q    <= wdata;
        s_q    <= wstrb;
      end
      if (wr_fire) begin
        aw_held <= 1'b0;
        w_held  <= 1'b0;
        bvalid  <= 1'b1;
      end else if (bvalid && bready) begin
        bvalid <= 1'b0;
      end
    end
  end

  assign arready = !rvalid;
  assign rd_fire = arvalid && arready;
  assign rd_addr = araddr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else if (rd_fire) begin
      rvalid <= 1'b1;
      rdata  <= rd_word;
    end else if (rvalid && rready) begin
      rvalid <= 1'b0;
    end
  end

  // R3: response only once both halves have been captured
  assert_resp_after_both_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bvalid) |-> $past(aw_held && w_held));
  assert_bhold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bvalid && !bready) |=> bvalid);
  // R11: read data held until accepted
  assert_rhold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rvalid && !rready) |=> (rvalid && $stable(rdata)));
endmodule

// File: rtl/acc_core.sv
module acc_core
  import acc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_set,
  input  logic             bv_wr,
  input  logic             bv_wval,
  input  logic             ctrl_rd,
  input  logic             cout_rd,
  input  logic [ARG_W-1:0] a_q,
  input  logic [ARG_W-1:0] b_q,
  input  logic [ARG_W-1:0] cin_q,
  output logic             start_q,
  output logic             done_q,
  output logic             idle,
  output logic             bv_q,
  output logic             cov_q,
  output logic [ARG_W-1:0] cout_q
);
  core_state_t st;
  logic start_accept, b_consume, post_taken;

  assign idle         = (st == CS_IDLE);
  assign start_accept = idle && start_q;
  assign b_consume    = (st == CS_WAIT) && bv_q;
  assign post_taken   = (st == CS_POST) && cout_rd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= CS_IDLE;
      start_q <= 1'b0;
      done_q  <= 1'b0;
      bv_q    <= 1'b0;
      cov_q   <= 1'b0;
      cout_q  <= '0;
    end else begin
      if (start_accept)            start_q <= 1'b0;
      else if (start_set && idle)  start_q <= 1'b1;

      if (bv_wr)          bv_q <= bv_wval;
      else if (b_consume) bv_q <= 1'b0;

      if (post_taken)     done_q <= 1'b1;
      else if (ctrl_rd)   done_q <= 1'b0;

      case (st)
        CS_IDLE: if (start_accept) st <= CS_WAIT;
        CS_WAIT: if (b_consume) begin
          st     <= CS_POST;
          cout_q <= acc_sum(cin_q, a_q, b_q);
          cov_q  <= 1'b1;
        end
        CS_POST: if (post_taken) begin
          st    <= CS_IDLE;
          cov_q <= 1'b0;
        end
        default: st <= CS_IDLE;
      endcase
    end
  end

  assert_start_clr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    start_accept |=> !start_q);
  assert_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == CS_WAIT && !bv_q) |=> (st == CS_WAIT && !cov_q));
  assert_bclr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (b_consume && !bv_wr) |=> !bv_q);
  assert_ovld_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cov_q) |-> $past(b_consume));
  assert_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> $past(cout_rd));
endmodule

// File: rtl/accel_ctl_adapter.sv
module accel_ctl_adapter
  import acc_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] s_awaddr,
  input  logic              s_awvalid,
  output logic              s_awready,
  input  logic [31:0]       s_wdata,
  input  logic [3:0]        s_wstrb,
  input  logic              s_wvalid,
  output logic              s_wready,
  output logic [1:0]        s_bresp,
  output logic              s_bvalid,
  input  logic              s_bready,
  input  logic [ADDR_W-1:0] s_araddr,
  input  logic              s_arvalid,
  output logic              s_arready,
  output logic [31:0]       s_rdata,
  output logic [1:0]        s_rresp,
  output logic              s_rvalid,
  input  logic              s_rready
);
  localparam int IDX_W = ADDR_W - 2;

  logic              wr_fire, rd_fire;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [BUS_W-1:0]  wr_data, rd_word;
  logic [3:0]        wr_strb;
  logic [IDX_W-1:0]  wr_idx, rd_idx;
  logic              wr_lo;
  logic [ARG_W-1:0]  a_q, b_q, cin_q, cout_q;
  logic              start_q, done_q, idle, bv_q, cov_q;

  assign s_bresp = 2'b00;
  assign s_rresp = 2'b00;
  assign wr_idx  = wr_addr[ADDR_W-1:2];
  assign rd_idx  = rd_addr[ADDR_W-1:2];
  assign wr_lo   = wr_fire && wr_strb[0];

  acc_axil_port #(.ADDR_W(ADDR_W), .DATA_W(BUS_W)) u_port (
    .clk(clk), .rst_n(rst_n),
    .awaddr(s_awaddr), .awvalid(s_awvalid), .awready(s_awready),
    .wdata(s_wdata), .wstrb(s_wstrb), .wvalid(s_wvalid), .wready(s_wready),
    .bvalid(s_bvalid), .bready(s_bready),
    .araddr(s_araddr), .arvalid(s_arvalid), .arready(s_arready),
    .rdata(s_rdata), .rvalid(s_rvalid), .rready(s_rready),
    .wr_fire(wr_fire), .wr_addr(wr_addr), .wr_data(wr_data), .wr_strb(wr_strb),
    .rd_fire(rd_fire), .rd_addr(rd_addr), .rd_word(rd_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_q   <= '0;
      b_q   <= '0;
      cin_q <= '0;
    end else if (wr_lo) begin
      if (wr_idx == IDX_W'(WI_A))  a_q   <= wr_data[ARG_W-1:0];
      if (wr_idx == IDX_W'(WI_B))  b_q   <= wr_data[ARG_W-1:0];
      if (wr_idx == IDX_W'(WI_CI)) cin_q <= wr_data[ARG_W-1:0];
    end
  end

  acc_core u_core (
    .clk(clk), .rst_n(rst_n),
    .start_set(wr_lo && wr_idx == IDX_W'(WI_CTRL) && wr_data[0]),
    .bv_wr(wr_lo && wr_idx == IDX_W'(WI_BV)),
    .bv_wval(wr_data[0]),
    .ctrl_rd(rd_fire && rd_idx == IDX_W'(WI_CTRL)),
    .cout_rd(rd_fire && rd_idx == IDX_W'(WI_CO)),
    .a_q(a_q), .b_q(b_q), .cin_q(cin_q),
    .start_q(start_q), .done_q(done_q), .idle(idle),
    .bv_q(bv_q), .cov_q(cov_q), .cout_q(cout_q)
  );

  always_comb begin
    rd_word = '0;
    case (int'(rd_idx))
      WI_CTRL: rd_word[2:0]       = {idle, done_q, start_q};
      WI_A:    rd_word[ARG_W-1:0] = a_q;
      WI_B:    rd_word[ARG_W-1:0] = b_q;
      WI_BV:   rd_word[0]         = bv_q;
      WI_CI:   rd_word[ARG_W-1:0] = cin_q;
      WI_CO:   rd_word[ARG_W-1:0] = cout_q;
      WI_COV:  rd_word[0]         = cov_q;
      default: rd_word = '0;
    endcase
  end

  // R2: no mapped word carries anything above bit 7
  assert_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    s_rvalid |-> (s_rdata[31:8] == 24'h0));
endmodule

// File: tb/accel_ctl_adapter_tb.sv
module accel_ctl_adapter_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  s_awaddr = '0;
  logic        s_awvalid = 1'b0;
  logic        s_awready;
  logic [31:0] s_wdata = '0;
  logic [3:0]  s_wstrb = '0;
  logic        s_wvalid = 1'b0;
  logic        s_wready;
  logic [1:0]  s_bresp;
  logic        s_bvalid;
  logic        s_bready = 1'b0;
  logic [5:0]  s_araddr = '0;
  logic        s_arvalid = 1'b0;
  logic        s_arready;
  logic [31:0] s_rdata;
  logic [1:0]  s_rresp;
  logic        s_rvalid;
  logic        s_rready = 1'b0;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  accel_ctl_adapter #(.ADDR_W(6)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .s_awaddr(s_awaddr), .s_awvalid(s_awvalid), .s_awready(s_awready),
    .s_wdata(s_wdata), .s_wstrb(s_wstrb), .s_wvalid(s_wvalid), .s_wready(s_wready),
    .s_bresp(s_bresp), .s_bvalid(s_bvalid), .s_bready(s_bready),
    .s_araddr(s_araddr), .s_arvalid(s_arvalid), .s_arready(s_arready),
    .s_rdata(s_rdata), .s_rresp(s_rresp), .s_rvalid(s_rvalid), .s_rready(s_rready)
  );

  task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  // order: 0 together, 1 address first, 2 data first
  task automatic axi_wr(input logic [5:0] addr, input logic [31:0] data, input int order);
    @(negedge clk);
    if (order != 2) begin s_awaddr = addr; s_awvalid = 1'b1; end
    if (order != 1) begin s_wdata = data; s_wstrb = 4'hF; s_wvalid = 1'b1; end
    while (!((order == 2 || s_awready) && (order == 1 || s_wready))) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    s_awvalid = 1'b0;
    s_wvalid  = 1'b0;
    if (order != 0) begin
      repeat (3) @(negedge clk);
      chk({31'b0, s_bvalid}, 32'h0, "R3 no response with one channel");
      if (order == 1) begin s_wdata = data; s_wstrb = 4'hF; s_wvalid = 1'b1; end
      else begin s_awaddr = addr; s_awvalid = 1'b1; end
      while (!(order == 1 ? s_wready : s_awready)) @(negedge clk);
      @(posedge clk);
      @(negedge clk);
      s_awvalid = 1'b0;
      s_wvalid  = 1'b0;
    end
    for (int n = 0; n < 50 && !s_bvalid; n++) @(negedge clk);
    if (!s_bvalid || s_bresp != 2'b00) begin
      checks++; errors++;
      $display("FAIL R3 write response got bvalid %0d bresp %0d exp 1 0", s_bvalid, s_bresp);
    end
    s_bready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    s_bready = 1'b0;
  endtask

  task automatic axi_rd(input logic [5:0] addr, output logic [31:0] data, input int hold);
    @(negedge clk);
    s_araddr = addr; s_arvalid = 1'b1;
    while (!s_arready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    s_arvalid = 1'b0;
    data = s_rdata;
    if (s_rresp != 2'b00) chk({30'b0, s_rresp}, 32'h0, "R10 rresp OKAY");
    if (hold > 0) begin
      repeat (hold) @(negedge clk);
      chk({31'b0, s_rvalid}, 32'h1, "R11 rvalid held");
      chk(s_rdata, data, "R11 rdata held");
    end
    s_rready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    s_rready = 1'b0;
  endtask

  task automatic expect_rd(input logic [5:0] addr, input logic [31:0] exp, input string tag);
    logic [31:0] d;
    axi_rd(addr, d, 0);
    chk(d, exp, tag);
  endtask

  task automatic t_reset();
    expect_rd(6'h00, 32'h4, "R1 control after reset");
    expect_rd(6'h1c, 32'h0, "R1 b valid after reset");
    expect_rd(6'h28, 32'h0, "R1 result after reset");
    expect_rd(6'h2c, 32'h0, "R1 result valid after reset");
  endtask

  task automatic t_mask();
    axi_wr(6'h10, 32'hDEADBEEF, 0);
    expect_rd(6'h10, 32'hEF, "R2 a low byte");
    axi_wr(6'h18, 32'h12345678, 1);
    expect_rd(6'h18, 32'h78, "R2 b low byte, R3 address first");
    axi_wr(6'h20, 32'hCAFE00A5, 2);
    expect_rd(6'h20, 32'hA5, "R2 c_in low byte, R3 data first");
  endtask

  task automatic t_unmapped();
    axi_wr(6'h24, 32'hFFFFFFFF, 0);
    axi_wr(6'h3c, 32'hFFFFFFFF, 0);
    axi_wr(6'h04, 32'hFFFFFFFF, 0);
    expect_rd(6'h24, 32'h0, "R10 reserved word");
    expect_rd(6'h3c, 32'h0, "R10 unmapped word");
    expect_rd(6'h04, 32'h0, "R10 unmapped word 0x04");
    expect_rd(6'h00, 32'h4, "R10 control untouched");
    expect_rd(6'h10, 32'hEF, "R10 a untouched");
  endtask

  task automatic t_rhold();
    logic [31:0] d;
    axi_rd(6'h18, d, 4);
    chk(d, 32'h78, "R11 held data value");
  endtask

  task automatic t_run(input logic [7:0] a0, input logic [7:0] a1,
                       input logic [7:0] b, input logic [7:0] c);
    int s;
    axi_wr(6'h10, {24'h0, a0}, 0);
    axi_wr(6'h18, {24'h0, b}, 0);
    axi_wr(6'h20, {24'h0, c}, 0);
    axi_wr(6'h00, 32'h1, 0);
    repeat (10) @(negedge clk);
    expect_rd(6'h00, 32'h0, "R4 start cleared and busy");
    expect_rd(6'h2c, 32'h0, "R5 no result while b flag low");
    axi_wr(6'h10, {24'h0, a1}, 1);
    axi_wr(6'h00, 32'h1, 0);
    repeat (10) @(negedge clk);
    expect_rd(6'h2c, 32'h0, "R5 still stalled");
    expect_rd(6'h00, 32'h0, "R4 start while busy ignored");
    axi_wr(6'h1c, 32'h1, 0);
    repeat (3) @(negedge clk);
    expect_rd(6'h1c, 32'h0, "R6 b flag cleared on consume");
    expect_rd(6'h2c, 32'h1, "R6 result valid");
    expect_rd(6'h00, 32'h0, "R8 no done before result read");
    s = (int'(c) + int'(a1) + int'(b)) % 256;
    expect_rd(6'h28, s[31:0], "R6 R7 result value");
    expect_rd(6'h2c, 32'h0, "R8 result valid cleared by read");
    expect_rd(6'h00, 32'h6, "R8 done and idle");
    expect_rd(6'h00, 32'h4, "R9 done cleared by read");
    repeat (10) @(negedge clk);
    expect_rd(6'h00, 32'h4, "R4 no second run");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_mask();
    t_unmapped();
    t_rhold();
    t_run(8'h11, 8'h37, 8'h22, 8'h05);
    t_run(8'h01, 8'h20, 8'h05, 8'hF0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule